// File: doc/BRIEF.md
# Predicate Mask Step Skipper

This block decides, at the start of a vector element iteration, where the source and destination element counters should really point. Each side has a 64-bit predicate mask. A clear bit means that element position is masked out. When a side is allowed to skip, its element step moves forward to the next position whose mask bit is set. If no set bit is found below the vector length, the step lands on the vector length. The caller reads a step equal to the vector length as "this instruction is done, move on".

When zeroing is enabled for a side, that side never skips. Its step stays where it is, and a per-side zero flag tells the datapath to write zero for a masked-out element instead of computing it. Sub-element steps are returned untouched.

Mask selection is done inside the block. With predication off, both masks are all ones. In single-predicate mode the destination mask serves both sides. In two-predicate mode the source side uses its own mask. Fetching the masks from the register files is the caller's job. A request strobe is answered with registered results one clock later.

Top module: `pred_step_skip`

## Requirements
- R1: While `reset_n` is low at a clock edge, every output register clears to zero: `out_valid`, both new steps, both sub steps and both zero flags.
- R2: With `pred_en` = 0, both effective masks are all ones. An in-range step is returned unchanged and no zero flag is raised.
- R3: With `pred_en` = 1 and `two_pred` = 0, `dst_mask` is used for both sides and `src_mask` is ignored. With `two_pred` = 1, the source side uses `src_mask`.
- R4: A side may skip only when its sub step is 0 and its zeroing enable is 0. Otherwise its new step equals its current step.
- R5: When a side skips, its new step is the lowest index i with step <= i < `vec_len` and mask bit i set.
- R6: When a side skips and no such bit exists, its new step equals `vec_len`.
- R7: With a side's zeroing enable set and step < `vec_len`, the step is unchanged. The zero flag is 1 exactly when mask bit [step] is 0, and this holds whatever the sub step is.
- R8: A side with zeroing disabled never raises its zero flag.
- R9: Both new sub steps equal the sub steps presented with the request.
- R10: A step at or beyond `vec_len` is returned unchanged with its zero flag 0.
- R11: The source and destination sides are computed independently. The settings of one side do not change the other side's results.
- R12: `out_valid` is 1 exactly in the cycle after a cycle with `req_valid` high. Outputs update only on a request and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe; inputs are sampled on this cycle |
| pred_en | input | 1 | Predication enable; 0 forces both masks to all ones |
| two_pred | input | 1 | 1 selects a separate source mask, 0 reuses the destination mask |
| src_mask | input | 64 | Source predicate mask (used only when two_pred = 1) |
| dst_mask | input | 64 | Destination predicate mask |
| src_step | input | 7 | Current source element step |
| dst_step | input | 7 | Current destination element step |
| src_sub | input | 2 | Current source sub-element step |
| dst_sub | input | 2 | Current destination sub-element step |
| vec_len | input | 7 | Vector length, 0 to 64 |
| src_zero_en | input | 1 | Source zeroing enable |
| dst_zero_en | input | 1 | Destination zeroing enable |
| out_valid | output | 1 | Results valid, one cycle after req_valid |
| new_src_step | output | 7 | Adjusted source element step |
| new_dst_step | output | 7 | Adjusted destination element step |
| new_src_sub | output | 2 | Source sub step, passed through |
| new_dst_sub | output | 2 | Destination sub step, passed through |
| src_zero | output | 1 | Source element must be zeroed |
| dst_zero | output | 1 | Destination element must be zeroed |

## Verification
Directed cases use sparse, single-bit and empty masks, placed around the current step and the vector length. They separate "lowest set bit at or above the step" from an off-by-one search. They also separate "land on the vector length" from "stop at the last set bit".

Contrasting masks on the two sides, combined with the predication and mode inputs, show which mask each side really uses. They also show that one side's zeroing or sub step does not leak into the other side.

The random phase draws dense and sparse masks, vector lengths from 0 to 64, and steps sometimes past the length. It sweeps all four zeroing combinations with zero and non-zero sub steps. Each result is compared with a bit-by-bit loop model.

// File: rtl/pss_pkg.sv
// Package: shared definitions for the predicate mask step skipper.
// Assumes: two sides only, source and destination.
package pss_pkg;
    typedef enum int {
        SIDE_SRC = 0,
        SIDE_DST = 1
    } side_e;

    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/pss_mask_select.sv
// Module: pss_mask_select
// Picks the effective mask for each side. With predication off, both
// masks are all ones. In single-predicate mode the destination mask
// feeds both sides.
// Assumes: purely combinational, no state.
module pss_mask_select #(
    parameter int MASK_W = 64
) (
    input  logic              pred_en,
    input  logic              two_pred,
    input  logic [MASK_W-1:0] src_mask_in,
    input  logic [MASK_W-1:0] dst_mask_in,
    output logic [MASK_W-1:0] src_mask_eff,
    output logic [MASK_W-1:0] dst_mask_eff
);
    // Mask routing by predication enable and predicate mode.
    always_comb begin
        if (!pred_en) begin
            src_mask_eff = '1;
            dst_mask_eff = '1;
        end else begin
            dst_mask_eff = dst_mask_in;
            src_mask_eff = two_pred ? src_mask_in : dst_mask_in;
        end
    end
endmodule

// File: rtl/pss_step_finder.sv
// Module: pss_step_finder
// For one side: finds the first set mask bit at or above the current
// step and below the vector length (the skip target), or works out the
// zero flag when zeroing is enabled.
// Assumes: vlen <= MASK_W; purely combinational.
module pss_step_finder #(
    parameter int MASK_W = 64,
    parameter int STEP_W = $clog2(MASK_W + 1),
    parameter int SUB_W  = 2
) (
    input  logic [MASK_W-1:0] mask,
    input  logic [STEP_W-1:0] step,
    input  logic [SUB_W-1:0]  sub,
    input  logic [STEP_W-1:0] vlen,
    input  logic              zero_en,
    output logic [STEP_W-1:0] new_step,
    output logic              zero_flag
);
    logic [MASK_W-1:0] cand;
    logic              hit;
    logic [STEP_W-1:0] hit_idx;
    logic              bit_at;
    logic              in_range;
    logic              skip_ok;

    // Window the mask to [step, vlen) and read the bit at the step.
    always_comb begin
        bit_at = 1'b0;
        for (int i = 0; i < MASK_W; i++) begin
            cand[i] = mask[i] && (STEP_W'(i) >= step) && (STEP_W'(i) < vlen);
            if (STEP_W'(i) == step) bit_at = mask[i];
        end
    end

    // Priority find of the lowest candidate bit.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit     = 1'b1;
                hit_idx = STEP_W'(i);
            end
        end
    end

    // Choose between skip, zero flag and pass-through.
    always_comb begin
        in_range  = step < vlen;
        skip_ok   = in_range && !zero_en && (sub == '0);
        new_step  = step;
        zero_flag = 1'b0;
        if (skip_ok)
            new_step = hit ? hit_idx : vlen;
        else if (in_range && zero_en)
            zero_flag = !bit_at;
    end
endmodule

// File: rtl/pred_step_skip.sv
// Module: pred_step_skip (top)
// Moves the source and destination element steps past masked-out
// positions at a sub-vector boundary, or flags zeroing. Results are
// registered one cycle after req_valid and held between requests.
// Assumes: vec_len <= MASK_W; synchronous active-low reset.
module pred_step_skip #(
    parameter int MASK_W = 64,
    parameter int SUB_W  = 2,
    localparam int STEP_W = $clog2(MASK_W + 1)
) (
    input  logic              clk,
    input  logic              reset_n,
    input  logic              req_valid,
    input  logic              pred_en,
    input  logic              two_pred,
    input  logic [MASK_W-1:0] src_mask,
    input  logic [MASK_W-1:0] dst_mask,
    input  logic [STEP_W-1:0] src_step,
    input  logic [STEP_W-1:0] dst_step,
    input  logic [SUB_W-1:0]  src_sub,
    input  logic [SUB_W-1:0]  dst_sub,
    input  logic [STEP_W-1:0] vec_len,
    input  logic              src_zero_en,
    input  logic              dst_zero_en,
    output logic              out_valid,
    output logic [STEP_W-1:0] new_src_step,
    output logic [STEP_W-1:0] new_dst_step,
    output logic [SUB_W-1:0]  new_src_sub,
    output logic [SUB_W-1:0]  new_dst_sub,
    output logic              src_zero,
    output logic              dst_zero
);
    import pss_pkg::*;

    logic [MASK_W-1:0] eff_mask [NUM_SIDES];
    logic [STEP_W-1:0] cur_step [NUM_SIDES];
    logic [SUB_W-1:0]  cur_sub  [NUM_SIDES];
    logic              zen      [NUM_SIDES];
    logic [STEP_W-1:0] nxt_step [NUM_SIDES];
    logic              nxt_zero [NUM_SIDES];

    pss_mask_select #(.MASK_W(MASK_W)) u_sel (
        .pred_en      (pred_en),
        .two_pred     (two_pred),
        .src_mask_in  (src_mask),
        .dst_mask_in  (dst_mask),
        .src_mask_eff (eff_mask[SIDE_SRC]),
        .dst_mask_eff (eff_mask[SIDE_DST])
    );

    // Gather the per-side request fields into side-indexed arrays.
    always_comb begin
        cur_step[SIDE_SRC] = src_step;
        cur_step[SIDE_DST] = dst_step;
        cur_sub[SIDE_SRC]  = src_sub;
        cur_sub[SIDE_DST]  = dst_sub;
        zen[SIDE_SRC]      = src_zero_en;
        zen[SIDE_DST]      = dst_zero_en;
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        pss_step_finder #(
            .MASK_W (MASK_W),
            .STEP_W (STEP_W),
            .SUB_W  (SUB_W)
        ) u_find (
            .mask      (eff_mask[g]),
            .step      (cur_step[g]),
            .sub       (cur_sub[g]),
            .vlen      (vec_len),
            .zero_en   (zen[g]),
            .new_step  (nxt_step[g]),
            .zero_flag (nxt_zero[g])
        );
    end

    // Register results on a request, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!reset_n) begin
            out_valid    <= 1'b0;
            new_src_step <= '0;
            new_dst_step <= '0;
            new_src_sub  <= '0;
            new_dst_sub  <= '0;
            src_zero     <= 1'b0;
            dst_zero     <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                new_src_step <= nxt_step[SIDE_SRC];
                new_dst_step <= nxt_step[SIDE_DST];
                new_src_sub  <= src_sub;
                new_dst_sub  <= dst_sub;
                src_zero     <= nxt_zero[SIDE_SRC];
                dst_zero     <= nxt_zero[SIDE_DST];
            end
        end
    end

    // R12: valid follows the request by one cycle.
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid |=> out_valid);
    a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (!reset_n)
        !req_valid |=> !out_valid && $stable(new_src_step) && $stable(new_dst_step));
    // R9: sub steps pass through.
    a_r9_sub_passthrough: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid |=> (new_src_sub == $past(src_sub)) && (new_dst_sub == $past(dst_sub)));
    // R4/R5: steps never move backwards.
    a_r5_forward_only: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid |=> (new_src_step >= $past(src_step)) && (new_dst_step >= $past(dst_step)));
    // R6: an in-range step never passes the vector length.
    a_r6_bounded_src: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid && (src_step <= vec_len) |=> new_src_step <= $past(vec_len));
    a_r6_bounded_dst: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid && (dst_step <= vec_len) |=> new_dst_step <= $past(vec_len));
    // R7: zeroing keeps the step in place.
    a_r7_zero_holds_src: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid && src_zero_en |=> new_src_step == $past(src_step));
    a_r7_zero_holds_dst: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid && dst_zero_en |=> new_dst_step == $past(dst_step));
    // R8: no zero flag without zeroing.
    a_r8_flag_needs_zen: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid |=> (!src_zero || $past(src_zero_en)) && (!dst_zero || $past(dst_zero_en)));
    // R4: a non-zero sub step blocks skipping.
    a_r4_sub_blocks_skip: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid && (src_sub != '0) |=> new_src_step == $past(src_step));
    // R10: out-of-range step is untouched and unflagged.
    a_r10_past_len: assert property (@(posedge clk) disable iff (!reset_n)
        req_valid && (dst_step >= vec_len) |=> (new_dst_step == $past(dst_step)) && !dst_zero);
endmodule

// File: tb/pred_step_skip_test.sv
module pred_step_skip_test;
    localparam int MW = 64;
    localparam int SW = 7;

    logic          clk = 1'b0;
    logic          reset_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          pred_en = 1'b0;
    logic          two_pred = 1'b0;
    logic [MW-1:0] src_mask = '0;
    logic [MW-1:0] dst_mask = '0;
    logic [SW-1:0] src_step = '0;
    logic [SW-1:0] dst_step = '0;
    logic [1:0]    src_sub = '0;
    logic [1:0]    dst_sub = '0;
    logic [SW-1:0] vec_len = '0;
    logic          src_zero_en = 1'b0;
    logic          dst_zero_en = 1'b0;
    logic          out_valid;
    logic [SW-1:0] new_src_step, new_dst_step;
    logic [1:0]    new_src_sub, new_dst_sub;
    logic          src_zero, dst_zero;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pred_step_skip uut (
        .clk(clk), .reset_n(reset_n), .req_valid(req_valid),
        .pred_en(pred_en), .two_pred(two_pred),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .src_step(src_step), .dst_step(dst_step),
        .src_sub(src_sub), .dst_sub(dst_sub), .vec_len(vec_len),
        .src_zero_en(src_zero_en), .dst_zero_en(dst_zero_en),
        .out_valid(out_valid),
        .new_src_step(new_src_step), .new_dst_step(new_dst_step),
        .new_src_sub(new_src_sub), .new_dst_sub(new_dst_sub),
        .src_zero(src_zero), .dst_zero(dst_zero)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bit-by-bit reference for the new step of one side.
    function automatic int ref_step(logic [MW-1:0] m, int st, int sb, int vl, bit zen);
        int s = st;
        if (st >= vl || zen || sb != 0) return st;
        while (s < vl && !m[s]) s++;
        return s;
    endfunction

    function automatic int ref_zero(logic [MW-1:0] m, int st, int vl, bit zen);
        if (!zen || st >= vl) return 0;
        return m[st] ? 0 : 1;
    endfunction

    // Issue one request, then check every output against the reference.
    task automatic run(input string tag, input bit pe, input bit tp,
                       input logic [MW-1:0] sm, input logic [MW-1:0] dm,
                       input int ss, input int ds, input int sb_s, input int sb_d,
                       input int vl, input bit zs, input bit zd);
        logic [MW-1:0] es, ed;
        @(negedge clk);
        req_valid = 1'b1; pred_en = pe; two_pred = tp;
        src_mask = sm; dst_mask = dm;
        src_step = SW'(ss); dst_step = SW'(ds);
        src_sub = 2'(sb_s); dst_sub = 2'(sb_d);
        vec_len = SW'(vl); src_zero_en = zs; dst_zero_en = zd;
        @(negedge clk);
        req_valid = 1'b0;
        ed = pe ? dm : '1;
        es = !pe ? '1 : (tp ? sm : dm);
        check({tag, " R12 valid"}, int'(out_valid), 1);
        check({tag, " src step"}, int'(new_src_step), ref_step(es, ss, sb_s, vl, zs));
        check({tag, " dst step"}, int'(new_dst_step), ref_step(ed, ds, sb_d, vl, zd));
        check({tag, " src zero"}, int'(src_zero), ref_zero(es, ss, vl, zs));
        check({tag, " dst zero"}, int'(dst_zero), ref_zero(ed, ds, vl, zd));
        check({tag, " R9 subs"}, int'({new_src_sub, new_dst_sub}), (sb_s << 2) | sb_d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 steps", int'(new_src_step) + int'(new_dst_step), 0);
        check("R1 subs/flags", int'({new_src_sub, new_dst_sub, src_zero, dst_zero}), 0);
        reset_n = 1'b1;

        // R2: predication off ignores the zero masks
        run("R2", 0, 1, '0, '0, 5, 9, 0, 0, 20, 1'b0, 1'b1);
        // R3: single-predicate mode uses dst_mask on both sides
        run("R3 single", 1, 0, 64'h1, 64'h100, 2, 3, 0, 0, 40, 0, 0);
        // R3: two-predicate mode uses src_mask for the source
        run("R3 two", 1, 1, 64'h1000, 64'h100, 2, 3, 0, 0, 40, 0, 0);
        // R5: lowest set bit at or above the step
        run("R5", 1, 1, 64'h0000_0000_0001_0011, 64'h8000_0000_0000_0000, 1, 0, 0, 0, 64, 0, 0);
        // R5: bit exactly at the step is kept
        run("R5 at", 1, 1, 64'h20, 64'h20, 5, 5, 0, 0, 64, 0, 0);
        // R6: set bit only at or beyond the length lands on vec_len
        run("R6", 1, 1, 64'h400, 64'h1, 3, 1, 0, 0, 10, 0, 0);
        run("R6 empty", 1, 1, '0, '0, 0, 0, 0, 0, 64, 0, 0);
        // R4: non-zero sub step blocks the skip
        run("R4", 1, 1, 64'h80, 64'h80, 2, 2, 1, 3, 30, 0, 0);
        // R7: zeroing holds the step and flags a clear bit, also with sub != 0
        run("R7", 1, 1, 64'h10, 64'h10, 3, 4, 2, 0, 30, 1, 1);
        // R8: zero flag stays low without zeroing on a clear bit
        run("R8", 1, 1, 64'h0, 64'h8, 6, 6, 1, 1, 30, 0, 0);
        // R10: step at and beyond the length
        run("R10", 1, 1, '0, '0, 12, 15, 0, 0, 12, 1, 0);
        run("R10 zero", 1, 1, '1, '1, 0, 0, 0, 0, 0, 1, 1);
        // R11: independent sides, one zeroing, the other skipping
        run("R11", 1, 1, 64'h0, 64'h200, 4, 4, 0, 0, 50, 1, 0);

        // R12: no request -> no valid, outputs held
        @(negedge clk);
        src_step = 7'd1; dst_step = 7'd1; vec_len = 7'd64; src_zero_en = 0; dst_zero_en = 0;
        src_mask = '1; dst_mask = '1;
        @(negedge clk);
        check("R12 no valid", int'(out_valid), 0);
        check("R12 hold src", int'(new_src_step), 4);
        check("R12 hold dst", int'(new_dst_step), 9);

        // Random phase: R5 R6 R7 R8 R10 R11 against the loop model
        for (int n = 0; n < 400; n++) begin
            logic [MW-1:0] sm, dm;
            int vl, ss, ds;
            sm = {$urandom, $urandom};
            dm = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 1) sm &= {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom_range(0, 1) == 1) dm &= {$urandom, $urandom} & {$urandom, $urandom};
            vl = $urandom_range(0, 64);
            ss = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 70) : $urandom_range(0, vl);
            ds = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 70) : $urandom_range(0, vl);
            run("rand", bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)), sm, dm, ss, ds,
                ($urandom_range(0, 1) == 1) ? $urandom_range(1, 3) : 0,
                ($urandom_range(0, 1) == 1) ? $urandom_range(1, 3) : 0,
                vl, bit'(n[0]), bit'(n[1]));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule